// File: doc/BRIEF.md
# Fixed-Burst Configuration Register Target for a Clock Generator

This block is a target-only I2C slave that holds the four 8-bit control bytes of a clock generator. It oversamples SCL and SDA with the system clock, finds START and STOP conditions, and answers one of two 7-bit addresses. A strap input picks which one. There is no register pointer. Every write carries exactly four data bytes, and every read returns all four bytes, always starting at byte 0.

Written bytes land in shadow storage. They are copied into the live registers together, and only when a STOP ends a write that delivered all four bytes. The live registers drive parallel fields: seventeen output enables, a 5-bit feedback divider code, a spread enable, a bypass select, a frequency select and a 7-bit identifier.

The protocol engine has eight named states:
- `ST_IDLE` ignores the bus until a START.
- `ST_ADDR` shifts in the address byte.
- `ST_ADDR_ACK` drives the address acknowledge.
- `ST_WR_BYTE` and `ST_WR_ACK` receive and acknowledge data bytes.
- `ST_WR_DONE` waits for STOP after the fourth byte.
- `ST_RD_BYTE` shifts a byte out.
- `ST_RD_ACK` samples the master's acknowledge.

The transitions are as follows:
- START enters `ST_ADDR` from any state.
- STOP enters `ST_IDLE` from any state.
- At the 8th SCL fall, `ST_ADDR` goes to `ST_ADDR_ACK` on an address match and to `ST_IDLE` on a mismatch.
- At the next SCL fall, `ST_ADDR_ACK` goes to `ST_WR_BYTE` or `ST_RD_BYTE`, depending on the R/W bit.
- After 8 bits, `ST_WR_BYTE` goes to `ST_WR_ACK`.
- `ST_WR_ACK` goes back to `ST_WR_BYTE`, or to `ST_WR_DONE` after byte 3.
- After 8 bits, `ST_RD_BYTE` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RD_BYTE` on a master ACK when bytes remain, and otherwise to `ST_IDLE`.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: After reset the bytes read 0xF7, 0xFF, 0xA0 and 0x53 (bytes 0 to 3). They map to ports as follows:
  - `out_en[16:9]` is byte 0 and `out_en[8:1]` is byte 1.
  - `out_en[0]` is byte 2 bit 7, `div_code` is byte 2 bits 6:2, `spread_en` is byte 2 bit 1 and `bypass_en` is byte 2 bit 0.
  - `freq_sel` is byte 3 bit 7 and `id_code` is byte 3 bits 6:0.
- R2: While `rst_n` is low, the reference-clock enables `out_en[11:0]` are all 0.
- R3: With `addr_sel`=0 the block acknowledges address bytes 0x9C (write) and 0x9D (read). With `addr_sel`=1 it acknowledges 0x98 and 0x99. It does not acknowledge the other pair.
- R4: An acknowledge holds SDA low through the whole SCL high phase of the ninth clock, and SDA is released within the following SCL low phase.
- R5: A write delivers bytes 0 to 3 in order, MSB first, and each byte is acknowledged. The outputs do not change until STOP; after STOP they show all four new bytes.
- R6: A STOP that arrives before all four data bytes of a write leaves every output unchanged.
- R7: A read returns live bytes 0 to 3 in order, MSB first. It continues after master ACKs, and after the master's NACK on byte 3 the block leaves SDA released.
- R8: When the address does not match, the block gives no ACK and ignores the rest of the transaction, including its data bytes, until the next START.
- R9: A repeated START restarts address reception and byte counting. Bytes sent before it are not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Selects which of the two slave addresses is answered |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_pull_low | output | 1 | Open-drain enable; 1 pulls SDA low, SDA is never driven high |
| out_en | output | 17 | Output enables; bits 11:0 are the reference-clock enables |
| div_code | output | 5 | Feedback divider code |
| spread_en | output | 1 | Spread-spectrum enable |
| bypass_en | output | 1 | PLL bypass select |
| freq_sel | output | 1 | Frequency select of the spread output |
| id_code | output | 7 | Revision and vendor identifier bits |

## Verification
The assertions take for granted that SCL and SDA are slow compared with `clk`. Each SCL phase must last many more clock cycles than the three-cycle synchronizer and history delay. SDA must change only while SCL is low, except when forming START or STOP, so that every edge seen after synchronization is unambiguous. The master model in the bench holds each quarter of an SCL period for ten clock cycles. It changes SDA only a quarter period after SCL falls, and it forms START and STOP only with SCL held high.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int NUM_BYTES  = 4;
    localparam int BYTE_W     = 8;
    localparam int IDX_W      = $clog2(NUM_BYTES);
    localparam int BIT_CNT_W  = $clog2(BYTE_W) + 1;
    localparam int OE_W       = 2 * BYTE_W + 1;
    localparam int REF_OE_W   = 12;
    localparam int DIV_W      = 5;
    localparam int ID_W       = 7;

    localparam logic [6:0] ADDR_STRAP_LO = 7'b1001110;
    localparam logic [6:0] ADDR_STRAP_HI = 7'b1001100;

    localparam logic [OE_W-1:0] REF_OE_MASK = OE_W'((1 << REF_OE_W) - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_WR_DONE,
        ST_RD_BYTE,
        ST_RD_ACK
    } slv_state_t;

    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'hF7;
            1:       return 8'hFF;
            2:       return 8'hA0;
            default: return 8'h53;
        endcase
    endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe[0] <= scl_i;
            sda_pipe[0] <= sda_i;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                scl_pipe[k] <= scl_pipe[k-1];
                sda_pipe[k] <= sda_pipe[k-1];
            end
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import clkcfg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [BYTE_W-1:0]           wr_data,
    input  logic                        commit,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [BYTE_W-1:0]           rd_data,
    output logic [NUM_BYTES*BYTE_W-1:0] live_flat
);
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] shadow_q;
        logic [BYTE_W-1:0] live_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q <= reg_default(g);
                live_q   <= reg_default(g);
            end else begin
                if (wr_en && (wr_idx == IDX_W'(g))) shadow_q <= wr_data;
                if (commit) live_q <= shadow_q;
            end
        end

        assign live_flat[g*BYTE_W +: BYTE_W] = live_q;
    end

    assign rd_data = live_flat[rd_idx*BYTE_W +: BYTE_W];
endmodule

// File: rtl/cfg_i2c_fsm.sv
module cfg_i2c_fsm
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              commit,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              sda_pull_low,
    output slv_state_t        state
);
    localparam logic [IDX_W-1:0]     LAST_IDX = IDX_W'(NUM_BYTES - 1);
    localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(BYTE_W);

    slv_state_t           state_q,  state_d;
    logic [BIT_CNT_W-1:0] bit_q,    bit_d;
    logic [IDX_W-1:0]     byte_q,   byte_d;
    logic [BYTE_W-1:0]    shift_q,  shift_d;
    logic                 rnw_q,    rnw_d;
    logic                 mack_q,   mack_d;
    logic                 full_q,   full_d;
    logic                 drive_q,  drive_d;
    logic [6:0]           my_addr;

    assign my_addr = addr_sel ? ADDR_STRAP_HI : ADDR_STRAP_LO;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            byte_q  <= '0;
            shift_q <= '0;
            rnw_q   <= 1'b0;
            mack_q  <= 1'b0;
            full_q  <= 1'b0;
            drive_q <= 1'b0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            byte_q  <= byte_d;
            shift_q <= shift_d;
            rnw_q   <= rnw_d;
            mack_q  <= mack_d;
            full_q  <= full_d;
            drive_q <= drive_d;
        end
    end

    assign rd_idx = (state_q == ST_RD_ACK) ? byte_q + 1'b1 : byte_q;

    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        byte_d  = byte_q;
        shift_d = shift_q;
        rnw_d   = rnw_q;
        mack_d  = mack_q;
        full_d  = full_q;
        drive_d = drive_q;
        wr_en   = 1'b0;
        commit  = 1'b0;
        if (stop_det) begin
            state_d = ST_IDLE;
            drive_d = 1'b0;
            commit  = full_q;
            full_d  = 1'b0;
        end else if (start_det) begin
            state_d = ST_ADDR;
            bit_d   = '0;
            byte_d  = '0;
            drive_d = 1'b0;
            full_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_WR_DONE: begin
                end
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shift_d = {shift_q[BYTE_W-2:0], sda_s};
                        bit_d   = bit_q + 1'b1;
                    end else if (scl_fall && bit_q == FULL_CNT) begin
                        if (state_q == ST_WR_BYTE) begin
                            wr_en   = 1'b1;
                            state_d = ST_WR_ACK;
                            drive_d = 1'b1;
                        end else if (shift_q[7:1] == my_addr) begin
                            state_d = ST_ADDR_ACK;
                            rnw_d   = shift_q[0];
                            drive_d = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        byte_d = '0;
                        if (rnw_q) begin
                            state_d = ST_RD_BYTE;
                            shift_d = rd_data;
                            drive_d = ~rd_data[BYTE_W-1];
                            bit_d   = BIT_CNT_W'(1);
                        end else begin
                            state_d = ST_WR_BYTE;
                            drive_d = 1'b0;
                            bit_d   = '0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        drive_d = 1'b0;
                        bit_d   = '0;
                        if (byte_q == LAST_IDX) begin
                            state_d = ST_WR_DONE;
                            full_d  = 1'b1;
                        end else begin
                            byte_d  = byte_q + 1'b1;
                            state_d = ST_WR_BYTE;
                        end
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (bit_q == FULL_CNT) begin
                            drive_d = 1'b0;
                            state_d = ST_RD_ACK;
                        end else begin
                            shift_d = {shift_q[BYTE_W-2:0], 1'b0};
                            drive_d = ~shift_q[BYTE_W-2];
                            bit_d   = bit_q + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack_d = ~sda_s;
                    end else if (scl_fall) begin
                        if (mack_q && byte_q != LAST_IDX) begin
                            byte_d  = byte_q + 1'b1;
                            state_d = ST_RD_BYTE;
                            shift_d = rd_data;
                            drive_d = ~rd_data[BYTE_W-1];
                            bit_d   = BIT_CNT_W'(1);
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign wr_idx       = byte_q;
    assign wr_data      = shift_q;
    assign sda_pull_low = drive_q;
    assign state        = state_q;
endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
    import clkcfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_sel,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_pull_low,
    output logic [OE_W-1:0] out_en,
    output logic [DIV_W-1:0] div_code,
    output logic            spread_en,
    output logic            bypass_en,
    output logic            freq_sel,
    output logic [ID_W-1:0] id_code
);
    logic                        sda_s;
    logic                        scl_rise;
    logic                        scl_fall;
    logic                        start_det;
    logic                        stop_det;
    logic                        wr_en;
    logic [IDX_W-1:0]            wr_idx;
    logic [BYTE_W-1:0]           wr_data;
    logic                        commit;
    logic [IDX_W-1:0]            rd_idx;
    logic [BYTE_W-1:0]           rd_data;
    logic [NUM_BYTES*BYTE_W-1:0] live_flat;
    slv_state_t                  fsm_state;
    logic [OE_W-1:0]             oe_raw;

    i2c_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_i2c_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_sel     (addr_sel),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .rd_data      (rd_data),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .commit       (commit),
        .rd_idx       (rd_idx),
        .sda_pull_low (sda_pull_low),
        .state        (fsm_state)
    );

    cfg_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .commit    (commit),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .live_flat (live_flat)
    );

    assign oe_raw    = {live_flat[0 +: BYTE_W], live_flat[BYTE_W +: BYTE_W],
                        live_flat[3*BYTE_W-1]};
    assign out_en    = rst_n ? oe_raw : (oe_raw & ~REF_OE_MASK);
    assign div_code  = live_flat[2*BYTE_W+2 +: DIV_W];
    assign spread_en = live_flat[2*BYTE_W+1];
    assign bypass_en = live_flat[2*BYTE_W];
    assign freq_sel  = live_flat[4*BYTE_W-1];
    assign id_code   = live_flat[3*BYTE_W +: ID_W];
endmodule

// File: rtl/clkcfg_i2c_chk.sv
module clkcfg_i2c_chk
    import clkcfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_fall,
    input logic             start_det,
    input logic             stop_det,
    input logic             commit,
    input logic             sda_pull_low,
    input slv_state_t       fsm_state,
    input logic [OE_W-1:0]  out_en,
    input logic [DIV_W-1:0] div_code,
    input logic             spread_en,
    input logic             bypass_en,
    input logic             freq_sel,
    input logic [ID_W-1:0]  id_code
);
    a_r2_ref_oe_off_in_reset: assert property (@(posedge clk)
        !rst_n |-> (out_en[REF_OE_W-1:0] == '0));

    a_r5_fields_hold_without_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_det |=> $stable({out_en, div_code, spread_en, bypass_en, freq_sel, id_code}));

    a_r5_commit_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> stop_det);

    a_r4_drive_moves_after_scl_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_low) |-> $past(scl_fall | start_det | stop_det));

    a_r8_idle_releases_sda: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> !sda_pull_low);
endmodule

bind clkgen_cfg_slave clkcfg_i2c_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .commit       (commit),
    .sda_pull_low (sda_pull_low),
    .fsm_state    (fsm_state),
    .out_en       (out_en),
    .div_code     (div_code),
    .spread_en    (spread_en),
    .bypass_en    (bypass_en),
    .freq_sel     (freq_sel),
    .id_code      (id_code)
);

// File: tb/tb_clkgen_cfg_slave.sv
`timescale 1ns/1ps
module tb_clkgen_cfg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_sel = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_pull_low;
    logic [16:0] out_en;
    logic [4:0]  div_code;
    logic        spread_en, bypass_en, freq_sel;
    logic [6:0]  id_code;
    logic        sda_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = m_sda & ~sda_pull_low;

    clkgen_cfg_slave dut (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull_low(sda_pull_low), .out_en(out_en), .div_code(div_code),
        .spread_en(spread_en), .bypass_en(bypass_en), .freq_sel(freq_sel), .id_code(id_code)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] regs_now();
        return {out_en[16:9], out_en[8:1], out_en[0], div_code, spread_en, bypass_en,
                freq_sel, id_code};
    endfunction

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    wait_q();
        m_scl = 1'b1; wait_q(); wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic recv_bit(output logic s1, output logic s2, output logic s3);
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        s1 = sda_line; wait_q();
        s2 = sda_line;
        m_scl = 1'b0; wait_q();
        s3 = sda_line;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack, output bit rel);
        logic s1, s2, s3;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(s1, s2, s3);
        ack = !s1 && !s2;
        rel = s3;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        logic s1, s2, s3;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(s1, s2, s3);
            b[i] = s2;
        end
        send_bit(!give_ack);
    endtask

    task automatic wr_txn(input logic [7:0] addr, input logic [31:0] data, input int nbytes,
                          output int acks);
        bit a, r;
        acks = 0;
        bus_start();
        send_byte(addr, a, r);
        if (a) acks++;
        for (int k = 0; k < nbytes; k++) begin
            send_byte(data[31-8*k -: 8], a, r);
            if (a) acks++;
        end
        bus_stop();
        repeat (8) @(negedge clk);
    endtask

    task automatic rd_txn(input logic [7:0] addr, output bit addr_ack,
                          output logic [31:0] data, output logic released);
        bit r;
        logic [7:0] b;
        data = '0;
        released = 1'b0;
        bus_start();
        send_byte(addr, addr_ack, r);
        if (addr_ack) begin
            for (int k = 0; k < 4; k++) begin
                recv_byte(k != 3, b);
                data[31-8*k -: 8] = b;
            end
            released = sda_line;
        end
        bus_stop();
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        check("R2 ref enables off in reset", {20'd0, out_en[11:0]}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 reset defaults", regs_now(), 32'hF7FFA053);
    endtask

    task automatic t_read_defaults();
        bit a; logic [31:0] d; logic rel;
        rd_txn(8'h9D, a, d, rel);
        check("R3 read addr 0x9D acked", {31'd0, a}, 32'd1);
        check("R7 read default bytes", d, 32'hF7FFA053);
        check("R7 SDA released after NACK", {31'd0, rel}, 32'd1);
    endtask

    task automatic t_write_commit();
        bit a, r; int acks = 0;
        bus_start();
        send_byte(8'h9C, a, r);
        check("R4 ack low through SCL high", {31'd0, a}, 32'd1);
        check("R4 SDA released after ack", {31'd0, r}, 32'd1);
        for (int k = 0; k < 4; k++) begin
            send_byte(32'h123456D9 >> (24 - 8*k), a, r);
            if (a) acks++;
        end
        check("R5 four data bytes acked", acks, 32'd4);
        repeat (20) @(negedge clk);
        check("R5 outputs held before STOP", regs_now(), 32'hF7FFA053);
        bus_stop();
        repeat (8) @(negedge clk);
        check("R5 committed at STOP", regs_now(), 32'h123456D9);
    endtask

    task automatic t_readback();
        bit a; logic [31:0] d; logic rel;
        rd_txn(8'h9D, a, d, rel);
        check("R7 readback acked", {31'd0, a}, 32'd1);
        check("R7 readback bytes", d, 32'h123456D9);
    endtask

    task automatic t_partial();
        int acks;
        wr_txn(8'h9C, 32'hAABBCCDD, 2, acks);
        check("R6 partial write acks", acks, 32'd3);
        check("R6 partial write discarded", regs_now(), 32'h123456D9);
    endtask

    task automatic t_addr_select();
        int acks; bit a; logic [31:0] d; logic rel;
        addr_sel = 1'b1;
        repeat (4) @(negedge clk);
        wr_txn(8'h9C, 32'h00000000, 4, acks);
        check("R8 mismatched write no ack", acks, 32'd0);
        check("R8 mismatched write ignored", regs_now(), 32'h123456D9);
        rd_txn(8'h9D, a, d, rel);
        check("R3 other-strap read nacked", {31'd0, a}, 32'd0);
        wr_txn(8'h98, 32'hF7FFA053, 4, acks);
        check("R3 strap-high write acked", acks, 32'd5);
        check("R3 strap-high write committed", regs_now(), 32'hF7FFA053);
        rd_txn(8'h99, a, d, rel);
        check("R3 strap-high read acked", {31'd0, a}, 32'd1);
        check("R3 strap-high read bytes", d, 32'hF7FFA053);
    endtask

    task automatic t_restart();
        bit a, r; int acks = 0;
        bus_start();
        send_byte(8'h98, a, r); if (a) acks++;
        send_byte(8'hAA, a, r); if (a) acks++;
        bus_start();
        send_byte(8'h98, a, r); if (a) acks++;
        for (int k = 0; k < 4; k++) begin
            send_byte(8'(k + 1), a, r);
            if (a) acks++;
        end
        bus_stop();
        repeat (8) @(negedge clk);
        check("R9 acks across repeated START", acks, 32'd7);
        check("R9 bytes after repeated START", regs_now(), 32'h01020304);
    endtask

    initial begin
        t_reset();
        t_read_defaults();
        t_write_commit();
        t_readback();
        t_partial();
        t_addr_select();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule